// File: doc/BRIEF.md
# Isochronous Schedule Safe-Window Calculator

This block follows the host controller's position in the periodic schedule and reports the earliest point where software may insert new isochronous work without racing the controller. It holds a free-running frame index, made of a 3-bit micro-frame number and a parameter-wide frame number, that steps once per micro-frame tick.

An 8-bit scheduling-threshold configuration selects one of three caching models:

- no caching;
- caching of a counted number of micro-frames;
- caching of a whole frame.

From the index and the selected model the block computes the earliest safe frame and micro-frame. It also reports which model is in force. Every calculation first allows one micro-frame of uncertainty in the controller's position. The outputs are registered. Software reads them when it places new isochronous descriptors.

Top module: `iso_safe_window`

## Requirements
- R1: A synchronous reset clears the micro-frame and frame counters, the safe frame and safe micro-frame outputs to zero, and sets the mode output to no caching (code 0).
- R2: On each clock with `tick_i` high the micro-frame counter advances by one modulo 8; with `tick_i` low both counters hold.
- R3: When the micro-frame counter steps from 7 to 0 the frame counter advances by one, wrapping from its maximum value to zero.
- R4: The mode decode works in priority order. Threshold bit 7 set selects frame caching (code 2), whatever the other bits hold. Otherwise a non-zero value in bits 2:0 selects micro-frame caching (code 1). Otherwise the mode is no caching (code 0). Bits 6:3 are never decoded.
- R5: With no caching, the safe position is the current position plus 2 micro-frames. The position is taken as frame*8 + micro-frame, and a carry out of the micro-frame field enters the frame number.
- R6: With micro-frame caching and a count C in bits 2:0, the safe position is the current position plus 1 plus C, with the same carry into the frame number.
- R7: With frame caching, take current frame N and adjusted micro-frame (u+1) mod 8. An adjusted value of 0 to 6 gives safe frame N+1, and 7 gives N+2, both modulo the frame range. The safe micro-frame is 0.
- R8: The safe and mode outputs are registered. They reflect the frame index and the threshold as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle micro-frame boundary pulse |
| thresh_i | input | 8 | Scheduling-threshold configuration |
| cur_frame_o | output | FRAME_W | Current frame number |
| cur_uframe_o | output | 3 | Current micro-frame number |
| safe_frame_o | output | FRAME_W | Earliest safe frame number |
| safe_uframe_o | output | 3 | Earliest safe micro-frame |
| cache_mode_o | output | 2 | Active caching model: 0 none, 1 micro-frame, 2 frame |

## Verification
The bench builds the block with FRAME_W set to 4, so the frame counter wraps after 128 ticks. This brings the carry of every safe-position calculation across the frame-number wrap within a short run. It also exercises the N+2 step of frame caching at the top of the frame range.

The threshold sweep covers every micro-frame count from 1 to 7, frame caching with and without low bits set, and values carrying only the undecoded middle bits. It also applies a reset in the middle of the run.

// File: rtl/iso_sched_pkg.sv
package iso_sched_pkg;
   localparam int UF_W       = 3;
   localparam int UF_PER_FR  = 1 << UF_W;
   localparam int THR_W      = 8;
   localparam int FRAME_SEL  = 7;

   typedef enum logic [1:0] {
      CACHE_NONE   = 2'd0,
      CACHE_UFRAME = 2'd1,
      CACHE_FRAME  = 2'd2
   } cache_mode_e;
endpackage

// File: rtl/iso_frame_counter.sv
module iso_frame_counter
   import iso_sched_pkg::*;
#(
   parameter int FRAME_W = 11
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   output logic [UF_W-1:0]    uframe,
   output logic [FRAME_W-1:0] frame
);
   localparam logic [UF_W-1:0] UF_LAST = UF_W'(UF_PER_FR - 1);

   logic wrap;
   assign wrap = tick && (uframe == UF_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         uframe <= '0;
      end else if (tick) begin
         uframe <= uframe + UF_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         frame <= '0;
      end else if (wrap) begin
         frame <= frame + FRAME_W'(1);
      end
   end
endmodule

// File: rtl/iso_thresh_decode.sv
module iso_thresh_decode
   import iso_sched_pkg::*;
(
   input  logic [THR_W-1:0] thresh,
   output cache_mode_e      mode,
   output logic [UF_W-1:0]  count
);
   always_comb begin
      count = thresh[UF_W-1:0];
      if (thresh[FRAME_SEL]) begin
         mode = CACHE_FRAME;
      end else if (count != '0) begin
         mode = CACHE_UFRAME;
      end else begin
         mode = CACHE_NONE;
      end
   end
endmodule

// File: rtl/iso_safe_calc.sv
module iso_safe_calc
   import iso_sched_pkg::*;
#(
   parameter int FRAME_W = 11
) (
   input  cache_mode_e        mode,
   input  logic [UF_W-1:0]    count,
   input  logic [UF_W-1:0]    uframe,
   input  logic [FRAME_W-1:0] frame,
   output logic [FRAME_W-1:0] safe_frame,
   output logic [UF_W-1:0]    safe_uframe
);
   localparam int POS_W = FRAME_W + UF_W;

   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] lead_pos;
   logic [UF_W-1:0]  lead;
   logic [UF_W-1:0]  adj_uf;
   logic [FRAME_W-1:0] frame_step;

   assign pos    = {frame, uframe};
   assign adj_uf = uframe + UF_W'(1);

   // distance ahead for the two position-based models
   always_comb begin
      if (mode == CACHE_UFRAME) begin
         lead = count;
      end else begin
         lead = UF_W'(1);
      end
   end

   assign lead_pos   = pos + POS_W'(1) + POS_W'(lead);
   assign frame_step = (adj_uf == UF_W'(UF_PER_FR - 1)) ? FRAME_W'(2) : FRAME_W'(1);

   always_comb begin
      if (mode == CACHE_FRAME) begin
         safe_frame  = frame + frame_step;
         safe_uframe = '0;
      end else begin
         safe_frame  = lead_pos[POS_W-1:UF_W];
         safe_uframe = lead_pos[UF_W-1:0];
      end
   end
endmodule

// File: rtl/iso_safe_window.sv
module iso_safe_window
   import iso_sched_pkg::*;
#(
   parameter int FRAME_W = 11
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick_i,
   input  logic [7:0]         thresh_i,
   output logic [FRAME_W-1:0] cur_frame_o,
   output logic [2:0]         cur_uframe_o,
   output logic [FRAME_W-1:0] safe_frame_o,
   output logic [2:0]         safe_uframe_o,
   output logic [1:0]         cache_mode_o
);
   generate
      if (FRAME_W < 2 || FRAME_W > 28) begin : g_bad_frame_w
         initial $fatal(1, "iso_safe_window: FRAME_W out of range");
      end
      if (UF_W != 3 || THR_W != 8) begin : g_bad_pkg
         initial $fatal(1, "iso_safe_window: package widths do not match ports");
      end
   endgenerate

   cache_mode_e        mode_d;
   logic [UF_W-1:0]    count_d;
   logic [FRAME_W-1:0] safe_frame_d;
   logic [UF_W-1:0]    safe_uframe_d;

   iso_frame_counter #(.FRAME_W(FRAME_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_i),
      .uframe (cur_uframe_o),
      .frame  (cur_frame_o)
   );

   iso_thresh_decode u_dec (
      .thresh (thresh_i),
      .mode   (mode_d),
      .count  (count_d)
   );

   iso_safe_calc #(.FRAME_W(FRAME_W)) u_calc (
      .mode        (mode_d),
      .count       (count_d),
      .uframe      (cur_uframe_o),
      .frame       (cur_frame_o),
      .safe_frame  (safe_frame_d),
      .safe_uframe (safe_uframe_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         safe_frame_o  <= '0;
         safe_uframe_o <= '0;
         cache_mode_o  <= CACHE_NONE;
      end else begin
         safe_frame_o  <= safe_frame_d;
         safe_uframe_o <= safe_uframe_d;
         cache_mode_o  <= mode_d;
      end
   end
endmodule

// File: rtl/iso_safe_window_chk.sv
module iso_safe_window_chk
   import iso_sched_pkg::*;
#(
   parameter int FRAME_W = 11
) (
   input logic               clk,
   input logic               rst,
   input logic               tick_i,
   input logic [7:0]         thresh_i,
   input logic [FRAME_W-1:0] cur_frame_o,
   input logic [2:0]         cur_uframe_o,
   input logic [FRAME_W-1:0] safe_frame_o,
   input logic [2:0]         safe_uframe_o,
   input logic [1:0]         cache_mode_o
);
   localparam int POS_W = FRAME_W + 3;

   logic rst_seen = 1'b0;
   always_ff @(posedge clk) rst_seen <= rst;

   always @(posedge clk) begin
      if (rst_seen) begin
         assert_reset_clear_R1: assert (cur_frame_o == '0 && cur_uframe_o == '0 &&
                                        safe_frame_o == '0 && safe_uframe_o == '0 &&
                                        cache_mode_o == 2'd0)
            else $error("reset state not cleared");
      end
   end

   assert_uframe_step_R2: assert property (@(posedge clk) disable iff (rst)
      tick_i |=> cur_uframe_o == $past(cur_uframe_o) + 3'd1);

   assert_index_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !tick_i |=> $stable(cur_uframe_o) && $stable(cur_frame_o));

   assert_frame_carry_R3: assert property (@(posedge clk) disable iff (rst)
      (tick_i && cur_uframe_o == 3'd7) |=> cur_frame_o == $past(cur_frame_o) + FRAME_W'(1));

   assert_frame_priority_R4: assert property (@(posedge clk) disable iff (rst)
      thresh_i[7] |=> cache_mode_o == 2'd2);

   assert_no_cache_lead_R5: assert property (@(posedge clk) disable iff (rst)
      (thresh_i == 8'd0) |=>
         {safe_frame_o, safe_uframe_o} == POS_W'({$past(cur_frame_o), $past(cur_uframe_o)} + POS_W'(2)));

   assert_frame_uframe_zero_R7: assert property (@(posedge clk) disable iff (rst)
      cache_mode_o == 2'd2 |-> safe_uframe_o == 3'd0);

   assert_frame_ahead_R7: assert property (@(posedge clk) disable iff (rst)
      (thresh_i[7] && cur_uframe_o != 3'd6) |=>
         safe_frame_o == $past(cur_frame_o) + FRAME_W'(1));
endmodule

bind iso_safe_window iso_safe_window_chk #(.FRAME_W(FRAME_W)) u_chk (.*);

// File: tb/sim_iso_safe_window.sv
module sim_iso_safe_window;
   localparam int FW   = 4;
   localparam int FMOD = 1 << FW;
   localparam int PMOD = FMOD * 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick_i = 1'b0;
   logic [7:0]    thresh_i = 8'd0;
   logic [FW-1:0] cur_frame_o, safe_frame_o;
   logic [2:0]    cur_uframe_o, safe_uframe_o;
   logic [1:0]    cache_mode_o;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;
   bit done    = 0;

   // reference model state
   int m_pos = 0;
   int e_pos = 0;
   int e_mode = 0;
   bit m_rst_prev = 1;

   always #5 clk = ~clk;

   iso_safe_window #(.FRAME_W(FW)) u0 (
      .clk(clk), .rst(rst), .tick_i(tick_i), .thresh_i(thresh_i),
      .cur_frame_o(cur_frame_o), .cur_uframe_o(cur_uframe_o),
      .safe_frame_o(safe_frame_o), .safe_uframe_o(safe_uframe_o),
      .cache_mode_o(cache_mode_o)
   );

   // behavioural model: outputs follow the index and threshold of the previous cycle (R8)
   always @(posedge clk) begin
      int n, u, adj, c;
      m_rst_prev = rst;
      if (rst) begin
         m_pos = 0; e_pos = 0; e_mode = 0;                     // R1
      end else begin
         n = m_pos / 8; u = m_pos % 8; c = thresh_i & 7;
         if (thresh_i[7]) begin                                 // R4, R7
            e_mode = 2;
            adj = (u + 1) % 8;
            e_pos = (((adj <= 6) ? n + 1 : n + 2) % FMOD) * 8;
         end else if (c != 0) begin                             // R4, R6
            e_mode = 1;
            e_pos = (m_pos + 1 + c) % PMOD;
         end else begin                                         // R4, R5
            e_mode = 0;
            e_pos = (m_pos + 2) % PMOD;
         end
         if (tick_i) m_pos = (m_pos + 1) % PMOD;                // R2, R3
      end
   end

   always @(negedge clk) begin
      int a_cur, a_safe;
      string tag;
      if (!done) begin
         a_cur  = int'(cur_frame_o) * 8 + int'(cur_uframe_o);
         a_safe = int'(safe_frame_o) * 8 + int'(safe_uframe_o);
         vectors++;
         if (a_cur != m_pos) begin
            fails++;
            tag = m_rst_prev ? "R1" : "R2 R3";
            $display("FAIL %s index: actual %0d expected %0d", tag, a_cur, m_pos);
         end
         if (int'(cache_mode_o) != e_mode) begin
            fails++;
            tag = m_rst_prev ? "R1" : "R4 R8";
            $display("FAIL %s mode: actual %0d expected %0d", tag, cache_mode_o, e_mode);
         end
         if (a_safe != e_pos) begin
            fails++;
            if (m_rst_prev) tag = "R1";
            else if (e_mode == 2) tag = "R7 R8";
            else if (e_mode == 1) tag = "R6 R8";
            else tag = "R5 R8";
            $display("FAIL %s safe f%0d.u%0d: actual %0d expected %0d",
                     tag, safe_frame_o, safe_uframe_o, a_safe, e_pos);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic run(input logic [7:0] thr, input int n, input int tick_pct);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         thresh_i = thr;
         tick_i = ($urandom_range(99) < tick_pct);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      run(8'h00, 300, 70);                                     // R5 with frame wrap
      for (int c = 1; c < 8; c++) run(8'(c), 150, 60);         // R6 every count
      run(8'h80, 300, 60);                                      // R7
      run(8'h87, 150, 100);                                     // R4 bit 7 priority
      run(8'h78, 150, 50);                                      // R4 bits 6:3 ignored
      run(8'h7B, 100, 50);                                      // R4 count 3 with upper bits
      for (int i = 0; i < 400; i++) run(8'($urandom_range(255)), 1, 50);
      @(negedge clk); rst = 1; tick_i = 1;                      // R1 mid-run reset
      run(8'h05, 1, 100);
      @(negedge clk); rst = 0;
      run(8'h80, 200, 100);                                     // R7 every micro-frame
      run(8'h00, 20, 0);                                        // R2 hold
      @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule